// File: doc/BRIEF.md
# Local Interrupt Timer with Deadline Mode

The block is a per-core timer that raises a one-cycle interrupt request, tagged with an 8-bit vector, when its programmed expiry is reached. It has three operating modes. In one-shot mode a current count is loaded from an initial count and steps down once per `tick_i` strobe, expiring once. In periodic mode it steps down the same way and reloads after every expiry. In deadline mode a 64-bit absolute deadline is compared against a free-running timestamp that enters the block on `tsc_i`.

Software reaches the block through four word addresses. Address 0 holds the timer entry, with vector, mask and mode fields. Address 1 holds the initial count, address 2 the current count (read-only) and address 3 the deadline. Reads are combinational from the registered state and the address. Writes take effect on the clock edge where `reg_we_i` is high.

Top module: `core_irq_timer`

## Requirements
- R1: After reset `irq_o` is low, the timer entry reads 0x10000 (mask set, vector 0, one-shot mode), and the initial count, current count and deadline all read zero.
- R2: Address map: 0 timer entry, 1 initial count, 2 current count, 3 deadline. In the timer entry, bits [7:0] are the vector, bit 16 is the mask and bits [18:17] are the mode: 00 one-shot, 01 periodic, 10 deadline, 11 reserved. The mode is decoded by comparing the whole field, and all other entry bits read zero. Writes to address 2 have no effect.
- R3: In one-shot mode, writing N to the initial count loads N into the current count. Each tick then lowers it by one. The tick that takes it from 1 to 0 raises `irq_o` for one cycle, starting the cycle after that edge. The count then stays at zero with no further interrupts.
- R4: In periodic mode, the tick that takes the count from 1 to 0 raises `irq_o` and reloads the current count from the initial count, so an initial count of N fires every N ticks.
- R5: Writing an initial count of zero stops the countdown, and no interrupt follows.
- R6: When the mode is neither one-shot nor periodic, the initial and current counts read zero and writes to the initial count are ignored.
- R7: A timer-entry write that changes the mode clears the initial count, current count and deadline, and cancels any pending expiry. A write that keeps the mode leaves the countdown running.
- R8: Outside deadline mode, the deadline reads zero and writes to it are discarded.
- R9: In deadline mode, a deadline write greater than the current timestamp is stored and arms the timer. The interrupt fires on the first edge where the timestamp is at or above it, and the deadline then reads zero.
- R10: In deadline mode, a nonzero deadline write not greater than the current timestamp stores zero and raises `irq_o` in the following cycle.
- R11: In deadline mode, a deadline write of zero stores zero, disarms the timer and raises no interrupt.
- R12: `irq_vec_o` carries the entry vector with each interrupt. A set mask suppresses `irq_o`, but expiries still update state: a one-shot count still reaches zero, and an expired deadline still clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Countdown decrement strobe |
| tsc_i | input | 64 | Free-running timestamp |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector accompanying `irq_o` |

## Verification
The bench targets several edge cases, and each would show a specific symptom if handled wrongly:
- **Deadline equal to the timestamp.** A design that compares with "greater or equal" here would arm the timer instead of firing at once, and the interrupt would arrive late.
- **Same-mode versus mode-changing entry writes.** A design that clears on every entry write would stall a running periodic count. One that never clears would leak a stale deadline or count into the new mode.
- **Masked expiries.** A design that stops its state machine when masked would leave the deadline or count non-zero.
- **Initial-count writes in deadline and reserved modes.** A design that decodes the mode from a single bit would accept these writes in the reserved mode.
- **64-bit timestamp values near the top of the range.** These expose a deadline comparator that is truncated to fewer bits.

// File: rtl/cit_pkg.sv
package cit_pkg;

    localparam int VEC_W    = 8;
    localparam int MASK_BIT = 16;
    localparam int MODE_LSB = 17;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10,
        MODE_RSVD     = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e        mode;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } lvt_t;

    localparam logic [1:0] ADDR_LVT  = 2'd0;
    localparam logic [1:0] ADDR_INIT = 2'd1;
    localparam logic [1:0] ADDR_CUR  = 2'd2;
    localparam logic [1:0] ADDR_DL   = 2'd3;

endpackage

// File: rtl/cit_countdown.sv
module cit_countdown
    import cit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    output logic [CNT_W-1:0] init_o,
    output logic [CNT_W-1:0] cur_o,
    output logic             fire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] cur;
    } cd_st_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cd_st_t st_d, st_q;
    logic   counting_mode;

    always_comb begin
        st_d          = st_q;
        fire_o        = 1'b0;
        counting_mode = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
        if (clr) begin
            st_d = '0;
        end else if (ld && counting_mode) begin
            st_d.init = ld_val;
            st_d.cur  = ld_val;
        end else if (tick && counting_mode && (st_q.cur != '0)) begin
            if (st_q.cur == ONE) begin
                fire_o   = 1'b1;
                st_d.cur = (mode == MODE_PERIODIC) ? st_q.init : '0;
            end else begin
                st_d.cur = st_q.cur - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign init_o = st_q.init;
    assign cur_o  = st_q.cur;

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr && counting_mode) |=> (cur_o == $past(ld_val)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cur_o == '0 && init_o == '0));

    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (cur_o <= init_o));

endmodule

// File: rtl/cit_deadline.sv
module cit_deadline #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic            wr,
    input  logic [TS_W-1:0] wr_val,
    input  logic [TS_W-1:0] tsc,
    output logic [TS_W-1:0] dl_o,
    output logic            fire_o
);

    logic [TS_W-1:0] dl_d, dl_q;

    always_comb begin
        dl_d   = dl_q;
        fire_o = 1'b0;
        if (clr) begin
            dl_d = '0;
        end else if (wr && en) begin
            if (wr_val > tsc) begin
                dl_d = wr_val;
            end else begin
                dl_d   = '0;
                fire_o = (wr_val != '0);
            end
        end else if ((dl_q != '0) && (tsc >= dl_q)) begin
            fire_o = 1'b1;
            dl_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= dl_d;
    end

    assign dl_o = dl_q;

    p_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && en && !clr && (wr_val > tsc)) |=> (dl_o == $past(wr_val)));

    p_expire_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (dl_o == '0));

    p_zero_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && en && !clr && (wr_val == '0)) |-> !fire_o);

endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
    import cit_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TS_W   = 64,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [TS_W-1:0]   tsc_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  irq_vec_o
);

    typedef struct packed {
        lvt_t             lvt;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } top_st_t;

    localparam lvt_t LVT_RST = '{mode: MODE_ONESHOT, mask: 1'b1, vector: '0};

    top_st_t         st_d, st_q;
    lvt_t            lvt_new;
    logic            wr_lvt, mode_chg, counting_mode;
    logic [CNT_W-1:0] init_cnt, cur_cnt;
    logic [TS_W-1:0]  dl_val;
    logic            fire_cd, fire_dl;

    always_comb begin
        lvt_new.vector = reg_wdata_i[VEC_W-1:0];
        lvt_new.mask   = reg_wdata_i[MASK_BIT];
        lvt_new.mode   = tmr_mode_e'(reg_wdata_i[MODE_LSB +: 2]);
        wr_lvt         = reg_we_i && (reg_addr_i == ADDR_LVT);
        mode_chg       = wr_lvt && (lvt_new.mode != st_q.lvt.mode);
        counting_mode  = (st_q.lvt.mode == MODE_ONESHOT) ||
                         (st_q.lvt.mode == MODE_PERIODIC);
    end

    cit_countdown #(.CNT_W(CNT_W)) u_countdown (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (st_q.lvt.mode),
        .clr    (mode_chg),
        .ld     (reg_we_i && (reg_addr_i == ADDR_INIT)),
        .ld_val (reg_wdata_i[CNT_W-1:0]),
        .tick   (tick_i),
        .init_o (init_cnt),
        .cur_o  (cur_cnt),
        .fire_o (fire_cd)
    );

    cit_deadline #(.TS_W(TS_W)) u_deadline (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (st_q.lvt.mode == MODE_DEADLINE),
        .clr    (mode_chg),
        .wr     (reg_we_i && (reg_addr_i == ADDR_DL)),
        .wr_val (reg_wdata_i[TS_W-1:0]),
        .tsc    (tsc_i),
        .dl_o   (dl_val),
        .fire_o (fire_dl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = (fire_cd || fire_dl) && !st_q.lvt.mask;
        st_d.vec = st_q.lvt.vector;
        if (wr_lvt) st_d.lvt = lvt_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{lvt: LVT_RST, irq: 1'b0, vec: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_LVT: begin
                reg_rdata_o[VEC_W-1:0]       = st_q.lvt.vector;
                reg_rdata_o[MASK_BIT]        = st_q.lvt.mask;
                reg_rdata_o[MODE_LSB +: 2]   = st_q.lvt.mode;
            end
            ADDR_INIT: if (counting_mode) reg_rdata_o[CNT_W-1:0] = init_cnt;
            ADDR_CUR:  if (counting_mode) reg_rdata_o[CNT_W-1:0] = cur_cnt;
            default:   if (st_q.lvt.mode == MODE_DEADLINE) reg_rdata_o[TS_W-1:0] = dl_val;
        endcase
    end

    assign irq_o     = st_q.irq;
    assign irq_vec_o = st_q.vec;

    p_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !$past(st_q.lvt.mask));

    p_vector_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_vec_o == $past(st_q.lvt.vector)));

    p_single_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_cd && fire_dl));

endmodule

// File: tb/core_irq_timer_tb.sv
`timescale 1ns/1ps
module core_irq_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [63:0] wdata = '0;
    logic [63:0] tsc = 64'd100;
    logic [63:0] rdata;
    logic        irq;
    logic [7:0]  vec;

    core_irq_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .tsc_i(tsc),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .irq_vec_o(vec)
    );

    always #2.5 clk = ~clk;

    int    n_vec = 0, n_bad = 0;
    int    irq_seen = 0, irq_exp = 0;
    int    tick_div = 1;
    string req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int unsigned m_mode = 0, m_vec = 0, m_mask = 1;
    longint unsigned m_init = 0, m_cur = 0, m_dl = 0;
    bit m_run = 0, e_irq = 0;
    int unsigned e_vec = 0;

    function automatic logic [63:0] m_read(logic [1:0] a);
        bit cd = (m_mode == 0) || (m_mode == 1);
        case (a)
            2'd0: return (64'(m_mode) << 17) | (64'(m_mask) << 16) | 64'(m_vec);
            2'd1: return cd ? m_init : 64'd0;
            2'd2: return cd ? m_cur : 64'd0;
            default: return (m_mode == 2) ? m_dl : 64'd0;
        endcase
    endfunction

    task automatic model_step();
        bit fire = 0;
        bit cd = (m_mode == 0) || (m_mode == 1);
        bit chg = we && addr == 2'd0 && (int'(wdata[18:17]) != m_mode);
        if (chg) begin
            m_init = 0; m_cur = 0; m_run = 0; m_dl = 0;
        end else begin
            if (we && addr == 2'd1 && cd) begin
                m_init = wdata[31:0]; m_cur = m_init; m_run = (m_init != 0);
            end else if (tick && m_run && cd) begin
                if (m_cur == 1) begin
                    fire = 1;
                    if (m_mode == 1) m_cur = m_init;
                    else begin m_cur = 0; m_run = 0; end
                end else m_cur = m_cur - 1;
            end
            if (we && addr == 2'd3 && m_mode == 2) begin
                if (wdata > tsc) m_dl = wdata;
                else begin m_dl = 0; if (wdata != 0) fire = 1; end
            end else if (m_dl != 0 && tsc >= m_dl) begin
                fire = 1; m_dl = 0;
            end
        end
        e_irq = fire && (m_mask == 0);
        e_vec = m_vec;
        if (we && addr == 2'd0) begin
            m_mode = wdata[18:17]; m_mask = wdata[16]; m_vec = wdata[7:0];
        end
    endtask

    task automatic check(string r, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req, "irq", 64'(irq), 64'(e_irq));
        if (e_irq) check(req, "vector", 64'(vec), 64'(e_vec));
        check(req, "rdata", rdata, m_read(addr));
        irq_seen += int'(irq);
        irq_exp  += int'(e_irq);
        we  = 1'b0;
        tsc = tsc + 64'd1;
        tick = (tick_div == 1) ? 1'b1 : ~tick;
    endtask

    task automatic wr(logic [1:0] a, logic [63:0] d);
        addr = a; wdata = d; we = 1'b1;
        cyc();
    endtask

    task automatic rd(logic [1:0] a, logic [63:0] exp, string r);
        addr = a;
        #0.5;
        check(r, "read", rdata, exp);
    endtask

    task automatic win(int n, int exp_cnt, string r);
        irq_seen = 0; irq_exp = 0;
        repeat (n) cyc();
        check(r, "irq count", 64'(irq_seen), 64'(exp_cnt));
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL %s watchdog: actual hung expected finished", req);
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] dval;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 64'h10000, "R1"); rd(2'd1, 0, "R1"); rd(2'd2, 0, "R1"); rd(2'd3, 0, "R1");
        check("R1", "irq", 64'(irq), 0);
        tick = 1'b1;

        // R3 one-shot, R2 read-only current count
        req = "R3";
        wr(2'd0, 64'h41);
        wr(2'd1, 64'd5);
        win(8, 1, "R3");
        rd(2'd2, 0, "R3");
        req = "R2";
        wr(2'd2, 64'd9);
        rd(2'd2, 0, "R2");

        // R4 periodic
        req = "R4";
        wr(2'd0, 64'h20052);
        wr(2'd1, 64'd3);
        win(10, 3, "R4");
        tick_div = 2;
        irq_seen = 0; irq_exp = 0;
        repeat (14) cyc();
        check("R4", "irq count slow tick", 64'(irq_seen), 64'(irq_exp));

        // R5 zero initial count stops
        req = "R5";
        wr(2'd1, 64'd0);
        win(6, 0, "R5");
        rd(2'd1, 0, "R5"); rd(2'd2, 0, "R5");
        tick_div = 1; tick = 1'b1;

        // R7 same-mode write keeps counting, mode change clears
        req = "R7";
        wr(2'd1, 64'd4);
        win(2, 0, "R7");
        wr(2'd0, 64'h20053);
        rd(2'd2, 64'd1, "R7");
        win(1, 1, "R7");
        wr(2'd0, 64'h53);
        rd(2'd1, 0, "R7"); rd(2'd2, 0, "R7");
        win(6, 0, "R7");

        // R6 count gating in deadline and reserved modes
        req = "R6";
        wr(2'd0, 64'h40060);
        wr(2'd1, 64'd7);
        rd(2'd1, 0, "R6"); rd(2'd2, 0, "R6");
        win(4, 0, "R6");
        wr(2'd0, 64'h60000);
        wr(2'd1, 64'd7);
        rd(2'd1, 0, "R6"); rd(2'd2, 0, "R6");
        win(4, 0, "R6");

        // R8 deadline gated outside deadline mode
        req = "R8";
        wr(2'd0, 64'h0);
        wr(2'd3, tsc + 64'd3);
        rd(2'd3, 0, "R8");
        win(5, 0, "R8");
        wr(2'd0, 64'h40066);
        rd(2'd3, 0, "R8");
        win(3, 0, "R8");

        // R9 armed deadline near the top of the 64-bit range
        req = "R9";
        tsc = 64'hFFFF_FFFF_FFFF_FF00;
        dval = tsc + 64'd6;
        wr(2'd3, dval);
        rd(2'd3, dval, "R9");
        win(10, 1, "R9");
        rd(2'd3, 0, "R9");

        // R10 past and equal deadline fire at once
        req = "R10";
        wr(2'd3, tsc - 64'd2);
        check("R10", "irq past", 64'(irq), 1);
        check("R10", "vector", 64'(vec), 64'h66);
        rd(2'd3, 0, "R10");
        wr(2'd3, tsc);
        check("R10", "irq equal", 64'(irq), 1);
        win(4, 0, "R10");

        // R11 zero write disarms
        req = "R11";
        wr(2'd3, tsc + 64'd5);
        wr(2'd3, 64'd0);
        check("R11", "irq", 64'(irq), 0);
        rd(2'd3, 0, "R11");
        win(8, 0, "R11");

        // R12 mask suppresses but state updates
        req = "R12";
        wr(2'd0, 64'h50070);
        wr(2'd3, tsc + 64'd3);
        win(6, 0, "R12");
        rd(2'd3, 0, "R12");
        wr(2'd0, 64'h10070);
        wr(2'd1, 64'd2);
        win(4, 0, "R12");
        rd(2'd2, 0, "R12");

        // R7 mode change cancels an armed deadline
        req = "R7";
        wr(2'd0, 64'h40071);
        wr(2'd3, tsc + 64'd4);
        wr(2'd0, 64'h20071);
        win(6, 0, "R7");
        wr(2'd0, 64'h40071);
        rd(2'd3, 0, "R7");
        win(2, 0, "R7");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule